// File: doc/BRIEF.md
# Autoreload Carrier Generator

This block produces a square-wave carrier on one output pin. A down-counter advances once for every instruction-cycle tick. Each time it passes zero it reloads from a host-held autoreload value and inverts the output. A reload value N therefore gives a half-period of N+1 ticks and a 50% duty cycle. Moving the mode input into an active code preloads the counter, so the first half-period has a known length.

In the gated mode, a pulse from an external timer's underflow turns the carrier on and the next pulse turns it off. This produces timed carrier bursts, for example for infrared transmission. The external timer is outside this block and appears here only as a one-cycle pulse. All other mode codes hold the output low.

Top module: `carrier_gen`

## Requirements
- R1: While reset is asserted (`rst_n` low), and at its release, `carrier_o` is 0.
- R2: Mode code 3'b001 selects the free-running carrier and 3'b011 selects the gated carrier. Every other code, including 3'b000, 3'b010 and any code with bit 2 set, holds `carrier_o` at 0 on the edge after it is applied, regardless of ticks.
- R3: On the edge where `mode_i` first takes an active code, or changes from one active code to the other, the counter loads `reload_i` and `carrier_o` goes to 0. With a tick on every cycle, the first rise of the carrier in free mode comes N+1 edges after that load edge.
- R4: The counter moves only on edges where `tick_i` is 1. With no ticks, `carrier_o` holds its value.
- R5: In free mode, each underflow inverts `carrier_o` and reloads the counter, so every high and every low phase lasts (N+1) ticks. N=0 inverts on every tick.
- R6: Entering gated mode leaves the burst off. While the burst is off, `carrier_o` is 0 and the counter stays at `reload_i`. An `ext_uf_i` pulse starts a burst. Its first rise comes N+1 ticks after the start edge, and then the phases repeat at N+1 ticks.
- R7: An `ext_uf_i` pulse during a burst ends it: `carrier_o` is 0 after that edge and stays 0 until the next start pulse.
- R8: Outside the gated mode, `ext_uf_i` has no effect on the carrier.
- R9: `reload_i` is sampled at each reload. A change affects only the phases that begin at or after the next underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle tick; the counter advances on it |
| mode_i | input | 3 | Mode code: 001 free, 011 gated, others idle |
| reload_i | input | CNT_W (8) | Autoreload value N |
| ext_uf_i | input | 1 | External timer underflow pulse; toggles the burst in gated mode |
| carrier_o | output | 1 | Carrier output |

## Verification
A wrong counter value or a skipped reload appears as a wrong phase length at `carrier_o`. It is visible within one half-period, at most 256 ticks. A missed preload on mode entry shows in the length of the first phase. A stuck burst flag appears either as a carrier during an "off" window or as silence after a start pulse, and both are seen within N+1 ticks. Wrong idle decoding drives the pin high on the very next edge.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
   localparam int unsigned MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_FREE  = 3'b001;
   localparam logic [MODE_W-1:0] MODE_GATED = 3'b011;

   function automatic logic mode_is_active(input logic [MODE_W-1:0] m);
      return (m == MODE_FREE) || (m == MODE_GATED);
   endfunction
endpackage

// File: rtl/carrier_mode_dec.sv
module carrier_mode_dec
   import carrier_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output logic              free_act_o,
   output logic              gate_act_o,
   output logic              load_o
);
   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= mode_i;
   end

   assign free_act_o = (mode_i == MODE_FREE);
   assign gate_act_o = (mode_i == MODE_GATED);
   // any step into an active code preloads the counter
   assign load_o     = mode_is_active(mode_i) && (mode_i != mode_q);
endmodule

// File: rtl/carrier_gate.sv
module carrier_gate #(
   parameter bit GATE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_act_i,
   input  logic load_i,
   input  logic ext_uf_i,
   output logic burst_on_o,
   output logic stop_o
);
   generate
      if (GATE_EN) begin : g_gate
         logic burst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      burst_q <= 1'b0;
            else if (!gate_act_i || load_i)  burst_q <= 1'b0;
            else if (ext_uf_i)               burst_q <= ~burst_q;
         end
         assign burst_on_o = burst_q;
         assign stop_o     = gate_act_i && !load_i && ext_uf_i && burst_q;
      end else begin : g_nogate
         assign burst_on_o = 1'b0;
         assign stop_o     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/carrier_counter.sv
module carrier_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             active_i,
   input  logic             run_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             out_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (hold_i) begin
         cnt_q <= reload_i;
         out_q <= 1'b0;
      end else if (!active_i) begin
         out_q <= 1'b0;
      end else if (run_i && tick_i) begin
         if (cnt_q == '0) begin
            cnt_q <= reload_i;
            out_q <= ~out_q;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign out_o = out_q;
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
   import carrier_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter bit          GATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [2:0]       mode_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             ext_uf_i,
   output logic             carrier_o
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("carrier_gen: CNT_W must be at least 2");
      end
      if (MODE_W != 3) begin : g_bad_mode
         $error("carrier_gen: mode field must be 3 bits");
      end
   endgenerate

   logic free_act, gate_act, load;
   logic burst_on, stop;
   logic active, run, hold;

   carrier_mode_dec u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .free_act_o (free_act),
      .gate_act_o (gate_act),
      .load_o     (load)
   );

   carrier_gate #(.GATE_EN(GATE_EN)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_act_i (gate_act),
      .load_i     (load),
      .ext_uf_i   (ext_uf_i),
      .burst_on_o (burst_on),
      .stop_o     (stop)
   );

   assign active = free_act || gate_act;
   assign run    = free_act || (gate_act && burst_on);
   assign hold   = load || (gate_act && !burst_on) || stop;

   carrier_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .active_i (active),
      .run_i    (run),
      .hold_i   (hold),
      .reload_i (reload_i),
      .out_o    (carrier_o)
   );
endmodule

// File: rtl/carrier_gen_chk.sv
module carrier_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic [2:0] mode_i,
   input logic       ext_uf_i,
   input logic       carrier_o
);
   logic act_now;
   assign act_now = (mode_i == 3'b001) || (mode_i == 3'b011);

   assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_now |=> !carrier_o);

   assert_entry_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_now && mode_i != $past(mode_i)) |=> !carrier_o);

   assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_now && mode_i == $past(mode_i) && !tick_i && !ext_uf_i) |=> $stable(carrier_o));

   assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b011 && $past(mode_i) == 3'b011 && ext_uf_i && carrier_o) |=> !carrier_o);

   assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b001 && $past(mode_i) == 3'b001 && ext_uf_i && !tick_i) |=> $stable(carrier_o));

   always_comb begin
      if (!rst_n) assert_reset_low_R1: assert (!carrier_o);
   end
endmodule

bind carrier_gen carrier_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .mode_i    (mode_i),
   .ext_uf_i  (ext_uf_i),
   .carrier_o (carrier_o)
);

// File: tb/carrier_gen_test.sv
module carrier_gen_test;
   localparam int CLK_P = 10;
   localparam int NVEC  = 6;
   // {reload, tick period, expected half-period in clocks}
   localparam logic [31:0] VECS [0:NVEC-1] = '{
      {8'd0,   8'd1, 16'd1},
      {8'd1,   8'd1, 16'd2},
      {8'd5,   8'd2, 16'd12},
      {8'd17,  8'd3, 16'd54},
      {8'd255, 8'd1, 16'd256},
      {8'd100, 8'd2, 16'd202}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [7:0] reload = 8'd0;
   logic       ext_uf = 1'b0;
   logic       carrier;
   int         tick_per = 1;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   carrier_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
      .reload_i(reload), .ext_uf_i(ext_uf), .carrier_o(carrier)
   );

   always #(CLK_P/2) clk = ~clk;

   initial begin : tick_gen
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         if (tick_per == 0) begin
            tick = 1'b0; ph = 0;
         end else begin
            tick = (ph == 0);
            ph = (ph + 1) % tick_per;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_change(output int n);
      logic p;
      p = carrier;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (carrier == p && n < 4000);
   endtask

   task automatic stay_low(input int cycles, input string req);
      int highs;
      highs = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (carrier) highs++;
      end
      check(highs == 0, req, highs, 0);
   endtask

   task automatic go_idle();
      mode = 3'b000;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int n, hi, lo, v, m;
      // R1: reset
      repeat (3) @(negedge clk);
      check(carrier == 1'b0, "R1 in reset", carrier, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(carrier == 1'b0, "R1 after release", carrier, 0);

      // R5 vector table
      for (int i = 0; i < NVEC; i++) begin
         go_idle();
         reload   = VECS[i][31:24];
         tick_per = int'(VECS[i][23:16]);
         @(negedge clk);
         @(negedge clk);
         mode = 3'b001;
         wait_change(n);
         if (tick_per == 1)
            check(n == int'(VECS[i][31:24]) + 2, "R3 first rise", n, int'(VECS[i][31:24]) + 2);
         wait_change(hi);
         wait_change(lo);
         check(hi == int'(VECS[i][15:0]), "R5 high phase", hi, int'(VECS[i][15:0]));
         check(lo == int'(VECS[i][15:0]), "R5 low phase", lo, int'(VECS[i][15:0]));
      end

      // R2: idle codes hold low even from a running carrier
      tick_per = 1;
      reload = 8'd2;
      mode = 3'b000; stay_low(30, "R2 code 000");
      mode = 3'b001; wait_change(n);
      mode = 3'b100; stay_low(30, "R2 code 100");
      mode = 3'b001; wait_change(n);
      mode = 3'b010; stay_low(30, "R2 code 010");
      mode = 3'b001; wait_change(n);
      mode = 3'b111; stay_low(30, "R2 code 111");

      // R3: active-to-active change drops the carrier
      mode = 3'b001; wait_change(n);
      check(carrier == 1'b1, "R3 running high", carrier, 1);
      mode = 3'b011;
      @(negedge clk);
      check(carrier == 1'b0, "R3 switch to gated", carrier, 0);

      // R4: no ticks, output frozen
      go_idle();
      reload = 8'd3;
      mode = 3'b001;
      wait_change(n);
      tick_per = 0;
      repeat (2) @(negedge clk);
      v = carrier;
      m = 0;
      repeat (40) begin
         @(negedge clk);
         if (carrier != v) m++;
      end
      check(m == 0, "R4 hold without tick", m, 0);
      tick_per = 1;
      wait_change(n);
      check(n <= 6, "R4 resumes on tick", n, 6);

      // R9: new reload takes effect after the next underflow
      go_idle();
      reload = 8'd3;
      mode = 3'b001;
      wait_change(n);
      reload = 8'd7;
      wait_change(n);
      wait_change(n);
      check(n == 8, "R9 new reload phase", n, 8);

      // R8: ext pulse ignored in free mode
      go_idle();
      reload = 8'd4;
      mode = 3'b001;
      wait_change(n);
      ext_uf = 1'b1;
      @(negedge clk);
      ext_uf = 1'b0;
      wait_change(m);
      check(m + 1 == 5, "R8 free phase unaffected", m + 1, 5);

      // R6 / R7: gated bursts
      go_idle();
      reload = 8'd2;
      mode = 3'b011;
      stay_low(20, "R6 burst off on entry");
      ext_uf = 1'b1;
      @(negedge clk);
      ext_uf = 1'b0;
      wait_change(n);
      check(n == 3, "R6 first rise after start", n, 3);
      wait_change(hi);
      wait_change(lo);
      check(hi == 3, "R6 burst high phase", hi, 3);
      check(lo == 3, "R6 burst low phase", lo, 3);
      check(carrier == 1'b1, "R6 high before stop", carrier, 1);
      ext_uf = 1'b1;
      @(negedge clk);
      ext_uf = 1'b0;
      check(carrier == 1'b0, "R7 stop drops carrier", carrier, 0);
      stay_low(20, "R7 stays off");
      ext_uf = 1'b1;
      @(negedge clk);
      ext_uf = 1'b0;
      wait_change(n);
      check(n == 3, "R6 restart first rise", n, 3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule